// File: doc/BRIEF.md
# Partitioned SIMD Integer Adder/Subtractor

This block is a 128-bit integer add/subtract unit for a vector datapath. Two source operands come in and one result goes out, which is the three-operand form. For ordinary sums and differences, a lane-size code splits the operands into sixteen byte lanes, eight halfword lanes or four word lanes. Carries never cross a lane edge, so every lane wraps modulo two to the power of its width.

Two flag operations return one bit for each 32-bit word: the carry of the unsigned sum, or a "no borrow" bit for the difference. Two doubleword operations treat the vector as two 64-bit integers in big-endian column order, where column 0 is bits [127:96] and column 3 is bits [31:0]. The carry or borrow out of columns 3 and 1 is fed into columns 2 and 0. The result and its valid flag are registered, so the result appears one cycle after the operands.

Top module: `simd_addsub`

## Requirements
- R1: With op_i=3'b000 the unit adds lane by lane. lane_i=2'b00 selects 8-bit lanes, 2'b01 selects 16-bit lanes and 2'b10 selects 32-bit lanes. No carry crosses a lane boundary, and each lane wraps modulo 2^width.
- R2: With op_i=3'b001 the unit computes a_i minus b_i in each lane, using the same lane codes as R1. Each lane wraps modulo 2^width and no borrow crosses a lane boundary.
- R3: With op_i=3'b010, bit 0 of each 32-bit word of the result is the carry out of the unsigned sum of that word. Bits 31:1 of each word are zero.
- R4: With op_i=3'b011, bit 0 of each 32-bit word is 1 exactly when a_i's word is greater than or equal to b_i's word, taken as unsigned (no borrow). Bits 31:1 of each word are zero.
- R5: With op_i=3'b100, result_o[127:64] and result_o[63:0] are the 64-bit sums of the matching halves of a_i and b_i, modulo 2^64.
- R6: With op_i=3'b101, each 64-bit half of the result is the 64-bit difference of a_i and b_i, modulo 2^64.
- R7: For op_i values 3'b010 through 3'b101, lane_i has no effect on the result.
- R8: An op_i of 3'b110 or 3'b111, or lane_i=2'b11 with op_i 3'b000 or 3'b001, gives an all-zero result. valid_o is still asserted for it.
- R9: valid_o is high in the cycle after the cycle in which valid_i is high, and low after a cycle in which valid_i is low. The result captured with valid_i appears at that same edge.
- R10: While rst_ni is low, valid_o and result_o are zero.
- R11: While valid_i is low, result_o keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and codes are valid this cycle |
| op_i | input | 3 | Operation code |
| lane_i | input | 2 | Lane size code |
| a_i | input | 128 | First operand |
| b_i | input | 128 | Second operand |
| valid_o | output | 1 | Result is valid |
| result_o | output | 128 | Registered result |

## Verification
The assertions take for granted that op_i, lane_i and both operands hold known values in every cycle where valid_i is high. The doubleword checks compare the result with a 64-bit sum or difference of the operands from the previous cycle, so they also assume those operands were sampled after reset had been released. The bench drives every input to a known value from time zero and changes them only on falling edges. Its random op and lane codes cover the full 3-bit and 2-bit spaces, so the undefined codes are exercised on purpose and not by leaving inputs unknown.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

  typedef enum logic [2:0] {
    OP_ADD      = 3'b000,
    OP_SUB      = 3'b001,
    OP_CARRY    = 3'b010,
    OP_NOBORROW = 3'b011,
    OP_ADD64    = 3'b100,
    OP_SUB64    = 3'b101
  } op_e;

  // lane code equals log2 of slices per lane
  typedef enum logic [1:0] {
    LANE_B8  = 2'b00,
    LANE_B16 = 2'b01,
    LANE_B32 = 2'b10
  } lane_e;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'b00,
    SEL_SUM  = 2'b01,
    SEL_FLAG = 2'b10
  } res_sel_e;

endpackage

// File: rtl/simd_addsub_dec.sv
module simd_addsub_dec
  import simd_addsub_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic [1:0] lane_i,
  output logic       sub_o,
  output logic [1:0] lane_log2_o,
  output logic       chain64_o,
  output res_sel_e   sel_o
);

  always_comb begin
    sub_o       = 1'b0;
    lane_log2_o = LANE_B32;
    chain64_o   = 1'b0;
    sel_o       = SEL_ZERO;
    case (op_e'(op_i))
      OP_ADD, OP_SUB: begin
        sub_o = (op_i == OP_SUB);
        if (lane_i != 2'b11) begin
          sel_o       = SEL_SUM;
          lane_log2_o = lane_i;
        end
      end
      OP_CARRY: sel_o = SEL_FLAG;
      OP_NOBORROW: begin
        sel_o = SEL_FLAG;
        sub_o = 1'b1;
      end
      OP_ADD64: begin
        sel_o     = SEL_SUM;
        chain64_o = 1'b1;
      end
      OP_SUB64: begin
        sel_o     = SEL_SUM;
        chain64_o = 1'b1;
        sub_o     = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/simd_word_unit.sv
module simd_word_unit #(
  parameter int WORD_W  = 32,
  parameter int SLICE_W = 8
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  input  logic [1:0]        lane_log2_i,
  input  logic              cin_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              cout_o
);

  localparam int SLICES = WORD_W / SLICE_W;
  localparam int SPAN_W = $clog2(SLICES) + 1;

  logic [WORD_W-1:0] b_eff;
  logic [SLICES:1]   c;
  logic [SPAN_W-1:0] span_mask;

  assign b_eff     = sub_i ? ~b_i : b_i;
  assign span_mask = SPAN_W'((1 << lane_log2_i) - 1);

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    logic           cin_k;
    logic [SLICE_W:0] t;
    if (k == 0) begin : g_first
      assign cin_k = cin_i;
    end else begin : g_rest
      // inside a lane: ripple; at a lane start: restart (1 for subtract)
      assign cin_k = ((SPAN_W'(k) & span_mask) != '0) ? c[k] : sub_i;
    end
    assign t = {1'b0, a_i[k*SLICE_W +: SLICE_W]}
             + {1'b0, b_eff[k*SLICE_W +: SLICE_W]}
             + (SLICE_W+1)'(cin_k);
    assign sum_o[k*SLICE_W +: SLICE_W] = t[SLICE_W-1:0];
    assign c[k+1] = t[SLICE_W];
  end

  assign cout_o = c[SLICES];

endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_addsub_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int WORD_W  = 32,
  parameter int SLICE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        lane_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);

  localparam int WORDS = DATA_W / WORD_W;
  localparam int DW_W  = 2 * WORD_W;

  logic        sub;
  logic [1:0]  lane_log2;
  logic        chain64;
  res_sel_e    sel;

  logic [WORDS-1:0]  cout;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] flag;
  logic [DATA_W-1:0] lsb_mask;
  logic [DATA_W-1:0] res_d;
  logic [DATA_W-1:0] result_q;
  logic              valid_q;

  simd_addsub_dec u_dec (
    .op_i       (op_i),
    .lane_i     (lane_i),
    .sub_o      (sub),
    .lane_log2_o(lane_log2),
    .chain64_o  (chain64),
    .sel_o      (sel)
  );

  // word 0 = bits [WORD_W-1:0] = least significant big-endian column
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic cin_w;
    if (i % 2 == 1) begin : g_hi
      assign cin_w = chain64 ? cout[i-1] : sub;
    end else begin : g_lo
      assign cin_w = sub;
    end

    simd_word_unit #(
      .WORD_W (WORD_W),
      .SLICE_W(SLICE_W)
    ) u_word (
      .a_i        (a_i[i*WORD_W +: WORD_W]),
      .b_i        (b_i[i*WORD_W +: WORD_W]),
      .sub_i      (sub),
      .lane_log2_i(lane_log2),
      .cin_i      (cin_w),
      .sum_o      (sum[i*WORD_W +: WORD_W]),
      .cout_o     (cout[i])
    );

    assign flag[i*WORD_W +: WORD_W]     = WORD_W'(cout[i]);
    assign lsb_mask[i*WORD_W +: WORD_W] = WORD_W'(1);
  end

  always_comb begin
    case (sel)
      SEL_SUM:  res_d = sum;
      SEL_FLAG: res_d = flag;
      default:  res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) result_q <= res_d;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = result_q;

  // R9
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R9
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R11
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  // R3 R4
  flag_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_CARRY || op_i == OP_NOBORROW))
      |=> ((result_o & ~lsb_mask) == '0));
  // R8
  undef_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i[2:1] == 2'b11 || (op_i[2:1] == 2'b00 && lane_i == 2'b11)))
      |=> (valid_o && result_o == '0));
  // R5
  add64_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ADD64)
      |=> (result_o[DW_W-1:0] == DW_W'($past(a_i[DW_W-1:0]) + $past(b_i[DW_W-1:0]))));
  // R6
  sub64_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SUB64)
      |=> (result_o[DW_W-1:0] == DW_W'($past(a_i[DW_W-1:0]) - $past(b_i[DW_W-1:0]))));

endmodule

// File: tb/simd_addsub_bench.sv
module simd_addsub_bench;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         valid_i;
  logic [2:0]   op_i;
  logic [1:0]   lane_i;
  logic [127:0] a_i, b_i;
  logic         valid_o;
  logic [127:0] result_o;

  int errors = 0;
  int checks = 0;

  always #2 clk_i = ~clk_i;

  simd_addsub u_simd_addsub (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .op_i    (op_i),
    .lane_i  (lane_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .valid_o (valid_o),
    .result_o(result_o)
  );

  function automatic logic [127:0] model(input logic [2:0] op, input logic [1:0] lane,
                                         input logic [127:0] a, input logic [127:0] b);
    logic [127:0] res = '0;
    longint unsigned x, y, r, m;
    int w;
    case (op)
      3'd0, 3'd1: begin
        if (lane != 2'b11) begin
          w = 8 << lane;
          m = (64'd1 << w) - 64'd1;
          for (int e = 0; e < 128 / w; e++) begin
            x = 64'(a >> (e * w)) & m;
            y = 64'(b >> (e * w)) & m;
            r = ((op == 3'd1) ? x - y : x + y) & m;
            res |= 128'(r) << (e * w);
          end
        end
      end
      3'd2, 3'd3: begin
        for (int e = 0; e < 4; e++) begin
          x = 64'(a >> (32 * e)) & 64'hFFFF_FFFF;
          y = 64'(b >> (32 * e)) & 64'hFFFF_FFFF;
          r = (op == 3'd2) ? ((x + y) >> 32) & 64'd1 : ((x >= y) ? 64'd1 : 64'd0);
          res |= 128'(r) << (32 * e);
        end
      end
      3'd4, 3'd5: begin
        for (int h = 0; h < 2; h++) begin
          x = 64'(a >> (64 * h));
          y = 64'(b >> (64 * h));
          r = (op == 3'd4) ? x + y : x - y;
          res |= 128'(r) << (64 * h);
        end
      end
      default: res = '0;
    endcase
    return res;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [1:0] lane,
                     input logic [127:0] a, input logic [127:0] b, input string tag);
    logic [127:0] exp;
    @(negedge clk_i);
    op_i = op; lane_i = lane; a_i = a; b_i = b; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    exp = model(op, lane, a, b);
    check({tag, " R9 valid"}, 128'(valid_o), 128'd1);
    check(tag, result_o, exp);
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic [1:0] lane);
    case (op)
      3'd0: return (lane == 2'b11) ? "R8 rand lane11" : "R1 rand";
      3'd1: return (lane == 2'b11) ? "R8 rand lane11" : "R2 rand";
      3'd2: return "R3 rand";
      3'd3: return "R4 rand";
      3'd4: return "R5 rand";
      3'd5: return "R6 rand";
      default: return "R8 rand";
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] held, ra, rb;
    logic [2:0]   rop;
    logic [1:0]   rlane;
    rst_ni = 1'b0; valid_i = 1'b0; op_i = '0; lane_i = '0; a_i = '0; b_i = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    check("R10 reset valid", 128'(valid_o), 128'd0);
    check("R10 reset result", result_o, 128'd0);
    rst_ni = 1'b1;

    run(3'd0, 2'b00, {16{8'hFF}}, {16{8'h01}}, "R1 8-bit wrap");
    run(3'd0, 2'b01, {8{16'h00FF}}, {8{16'h0001}}, "R1 16-bit inner carry");
    run(3'd0, 2'b10, {4{32'hFFFF_FFFF}}, {4{32'h1}}, "R1 32-bit wrap");
    run(3'd1, 2'b00, 128'd0, {16{8'h01}}, "R2 8-bit borrow wrap");
    run(3'd1, 2'b01, {8{16'h0100}}, {8{16'h0001}}, "R2 16-bit inner borrow");
    run(3'd2, 2'b00, {32'hFFFF_FFFF, 32'h1, 32'h8000_0000, 32'h0},
                     {32'h1, 32'h1, 32'h8000_0000, 32'h0}, "R3 carry flags");
    run(3'd3, 2'b01, {32'h5, 32'h4, 32'h0, 32'h7},
                     {32'h5, 32'h5, 32'h1, 32'h6}, "R4 no-borrow flags");
    run(3'd4, 2'b00, {64'h0000_0001_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
                     {64'h1, 64'h1}, "R5 add64 column carry");
    run(3'd5, 2'b00, {64'h1_0000_0000, 64'h0}, {64'h1, 64'h1}, "R6 sub64 column borrow");
    run(3'd4, 2'b11, {64'h0000_0001_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
                     {64'h1, 64'h1}, "R7 add64 lane11");
    run(3'd2, 2'b11, {4{32'hFFFF_FFFF}}, {4{32'h1}}, "R7 carry lane11");
    run(3'd5, 2'b01, {64'h1_0000_0000, 64'h0}, {64'h1, 64'h1}, "R7 sub64 lane01");
    run(3'd6, 2'b00, {4{32'h1234_5678}}, {4{32'h1}}, "R8 op 110");
    run(3'd7, 2'b10, {4{32'h1234_5678}}, {4{32'h1}}, "R8 op 111");
    run(3'd0, 2'b11, {4{32'h1234_5678}}, {4{32'h1}}, "R8 add lane11");

    run(3'd1, 2'b10, {4{32'h10}}, {4{32'h3}}, "R2 32-bit");
    held = model(3'd1, 2'b10, {4{32'h10}}, {4{32'h3}});
    a_i = '1; b_i = '1; op_i = 3'd0;
    @(negedge clk_i);
    check("R9 idle valid low", 128'(valid_o), 128'd0);
    check("R11 result held", result_o, held);

    for (int n = 0; n < 400; n++) begin
      rop   = 3'($urandom_range(7, 0));
      rlane = 2'($urandom_range(3, 0));
      ra    = {$urandom, $urandom, $urandom, $urandom};
      rb    = {$urandom, $urandom, $urandom, $urandom};
      case ($urandom_range(3, 0))
        0: rb = ~ra;
        1: rb = '1;
        default: ;
      endcase
      run(rop, rlane, ra, rb, tag_of(rop, rlane));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule